// File: doc/BRIEF.md
# DRAM Row/Column Sequencer with Area Mapping

This block sits between a processor's external bus and DRAM that is wired straight to it. The bus address space is split into eight areas, numbered by the top three address bits. A three-bit mapping field turns some of areas 2 to 5 into DRAM. The choices are none, area 2 alone, areas 2 and 3 as two separate DRAM spaces, or areas 2 to 5 joined into one continuous region. Every other area stays normal space and is left to other logic.

For a DRAM access the block drives the row address with one RAS strobe low, and the column address with CAS low one clock later. It holds CAS for the wait states set for that area and then pulses ready to the master. The row address is the bus address shifted right by 8, 9, 10 or 11 bits, as a shift-select field chooses. If the next request hits the same open row of the same RAS, the block repeats only the column phase (fast page mode). A miss, or a cycle with no request, closes the row with a precharge.

The master holds `req` and `addr` until it sees `rdy`. It may present the next request from the clock after `rdy`.

Top module: `dram_mux_ctrl`

## Requirements
- R1: Mapping code 000 and every code with bit 2 set leave all areas as normal space. A request then asserts no RAS and gets no `rdy`.
- R2: Mapping code 001 makes area 2 DRAM on `ras_n[0]`. Area 3 stays normal.
- R3: Mapping code 010 makes area 2 DRAM on `ras_n[0]` and area 3 DRAM on `ras_n[1]`. Areas 4 and 5 stay normal.
- R4: Mapping code 011 makes areas 2 to 5 one region. It uses only `ras_n[0]`, and the area-2 wait field (`wait_cfg[1:0]`) applies to every access in it.
- R5: In the cycle after an access is accepted from idle, one RAS is low and CAS is high. `dram_addr` then equals bits [11:0] of `addr >> (8 + shift_sel[1:0])`. This row phase lasts exactly one cycle.
- R6: In the column phase `dram_addr` equals `addr` masked to its low `8 + shift_sel[1:0]` bits. CAS stays low for W+1 cycles, where W is the wait field of the area (bits [2k+1:2k] of `wait_cfg` for area 2+k).
- R7: `rdy` is high for exactly one cycle, in the cycle after the last CAS-low cycle. In that cycle CAS is high and RAS is still low.
- R8: A request presented in the cycle after `rdy` to the same RAS and the same row (same `addr >> shift`) starts the column phase in the next cycle. RAS stays low throughout.
- R9: A row or RAS change, or a cycle with no request after `rdy`, drives all RAS high. Any RAS that rises stays high for at least one further cycle. A new access then starts with a row phase.
- R10: When `shift_sel[2]` is 1, `cfg_err` is high from the next cycle and no DRAM access is started.
- R11: During and right after reset, all RAS and CAS are high, `rdy` and `cfg_err` are low and `dram_addr` is zero.
- R12: At most one RAS is low at any time. Areas 0, 1, 6 and 7 never start a DRAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until `rdy` |
| addr | input | ADDR_W (24) | Bus address; bits [23:21] give the area number |
| map_sel | input | 3 | Area-mapping code |
| shift_sel | input | 3 | Row shift select; bits [1:0] give the shift minus 8, bit 2 must be 0 |
| wait_cfg | input | 4*WAIT_W (8) | Wait states per area 2..5, area 2 in the lowest field |
| ras_n | output | 4 | Row strobes, active low, bit k for area 2+k |
| cas_n | output | 1 | Column strobe, active low |
| dram_addr | output | MA_W (12) | Multiplexed row/column address |
| rdy | output | 1 | One-cycle access-complete pulse |
| cfg_err | output | 1 | Shift-select top bit set |

## Verification
A wrong sequencer state shows at the strobes within one or two cycles. Examples are a row phase that is skipped or repeated, a CAS window of the wrong length, or RAS left low across a row change. The bench counts the cycles before CAS falls and the number of CAS-low cycles for every access. A wrong open-row record shows on the next burst request: the bench sees a precharge where a page hit was due, or the reverse. Faults in the area decode or the shift mux show at once as the wrong RAS bit or a wrong address value in the row or column cycle.

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_RDY,
    ST_PAGE,
    ST_PRE
  } seq_state_t;

  localparam logic [2:0] MAP_NONE = 3'b000;
  localparam logic [2:0] MAP_ONE  = 3'b001;
  localparam logic [2:0] MAP_TWO  = 3'b010;
  localparam logic [2:0] MAP_CONT = 3'b011;

  localparam int FIRST_DRAM_AREA = 2;
  localparam int AREA_BITS       = 3;

endpackage

// File: rtl/dram_area_map.sv
module dram_area_map
  import dram_pkg::*;
#(
  parameter int N_SLOT = 4,
  parameter int WAIT_W = 2
) (
  input  logic [2:0]               map_sel,
  input  logic                     shift_bad,
  input  logic [AREA_BITS-1:0]     area,
  input  logic [N_SLOT*WAIT_W-1:0] wait_cfg,
  output logic                     dram_hit,
  output logic [$clog2(N_SLOT)-1:0] slot,
  output logic [WAIT_W-1:0]        wait_n
);
  localparam int SLOT_W = $clog2(N_SLOT);

  logic [N_SLOT-1:0] slot_en;
  logic [N_SLOT-1:0] area_sel;
  logic [SLOT_W-1:0] area_slot;

  generate
    for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
      assign slot_en[k]  = (map_sel == MAP_CONT) ||
                           (map_sel == MAP_ONE && k < 1) ||
                           (map_sel == MAP_TWO && k < 2);
      assign area_sel[k] = (area == AREA_BITS'(FIRST_DRAM_AREA + k));
    end
  endgenerate

  always_comb begin
    area_slot = '0;
    for (int k = 0; k < N_SLOT; k++) begin
      if (area_sel[k]) area_slot = SLOT_W'(k);
    end
    dram_hit = !shift_bad && |(slot_en & area_sel);
    slot     = (map_sel == MAP_CONT) ? '0 : area_slot;
    wait_n   = wait_cfg[slot*WAIT_W +: WAIT_W];
  end

endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int ADDR_W     = 24,
  parameter int MA_W       = 12,
  parameter int SHIFT_BASE = 8,
  parameter int N_SHIFT    = 4
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [$clog2(N_SHIFT)-1:0] shift_sel,
  output logic [ADDR_W-1:0]          row_key,
  output logic [MA_W-1:0]            row_addr,
  output logic [MA_W-1:0]            col_addr
);
  logic [ADDR_W-1:0] shifted [N_SHIFT];
  logic [MA_W-1:0]   masks   [N_SHIFT];

  generate
    for (genvar j = 0; j < N_SHIFT; j++) begin : g_shift
      assign shifted[j] = addr >> (SHIFT_BASE + j);
      assign masks[j]   = MA_W'((64'd1 << (SHIFT_BASE + j)) - 64'd1);
    end
  endgenerate

  always_comb begin
    row_key  = shifted[shift_sel];
    row_addr = row_key[MA_W-1:0];
    col_addr = addr[MA_W-1:0] & masks[shift_sel];
  end

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int MA_W   = 12,
  parameter int N_SLOT = 4,
  parameter int WAIT_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req,
  input  logic                      dram_hit,
  input  logic [$clog2(N_SLOT)-1:0] slot,
  input  logic [ADDR_W-1:0]         row_key,
  input  logic [MA_W-1:0]           row_addr,
  input  logic [MA_W-1:0]           col_addr,
  input  logic [WAIT_W-1:0]         wait_n,
  output logic [N_SLOT-1:0]         ras_n,
  output logic                      cas_n,
  output logic [MA_W-1:0]           ma,
  output logic                      rdy
);
  localparam int SLOT_W = $clog2(N_SLOT);

  seq_state_t        state;
  logic [WAIT_W-1:0] wcnt;
  logic [SLOT_W-1:0] open_slot;
  logic [ADDR_W-1:0] open_row;
  logic              page_hit;

  assign page_hit = req && dram_hit && (slot == open_slot) && (row_key == open_row);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ras_n     <= '1;
      cas_n     <= 1'b1;
      ma        <= '0;
      rdy       <= 1'b0;
      wcnt      <= '0;
      open_slot <= '0;
      open_row  <= '0;
    end else begin
      rdy <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req && dram_hit) begin
            state     <= ST_ROW;
            ras_n     <= ~(N_SLOT'(1) << slot);
            ma        <= row_addr;
            open_slot <= slot;
            open_row  <= row_key;
            wcnt      <= wait_n;
          end
        end
        ST_ROW: begin
          state <= ST_COL;
          cas_n <= 1'b0;
          ma    <= col_addr;
        end
        ST_COL: begin
          if (wcnt == '0) begin
            state <= ST_RDY;
            cas_n <= 1'b1;
            rdy   <= 1'b1;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        ST_RDY: state <= ST_PAGE;
        ST_PAGE: begin
          if (page_hit) begin
            state <= ST_COL;
            cas_n <= 1'b0;
            ma    <= col_addr;
            wcnt  <= wait_n;
          end else begin
            state <= ST_PRE;
            ras_n <= '1;
          end
        end
        ST_PRE:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RAS_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ras_n)); // R12

  AST_RDY_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy); // R7

  AST_RDY_CAS_HIGH_RAS_LOW: assert property (@(posedge clk) disable iff (rst)
    rdy |-> (cas_n && ras_n != '1)); // R7

  AST_CAS_AFTER_ROW: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> ($past(ras_n) != '1)); // R5

  AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> (ras_n != '1)); // R6

  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (rst)
    (ras_n == '1 && $past(ras_n) != '1) |=> (ras_n == '1)); // R9

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
  import dram_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int MA_W       = 12,
  parameter int WAIT_W     = 2,
  parameter int N_SLOT     = 4,
  parameter int SHIFT_BASE = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [2:0]               map_sel,
  input  logic [2:0]               shift_sel,
  input  logic [N_SLOT*WAIT_W-1:0] wait_cfg,
  output logic [N_SLOT-1:0]        ras_n,
  output logic                     cas_n,
  output logic [MA_W-1:0]          dram_addr,
  output logic                     rdy,
  output logic                     cfg_err
);
  localparam int SLOT_W = $clog2(N_SLOT);

  logic                 dram_hit;
  logic [SLOT_W-1:0]    slot;
  logic [WAIT_W-1:0]    wait_n;
  logic [ADDR_W-1:0]    row_key;
  logic [MA_W-1:0]      row_addr;
  logic [MA_W-1:0]      col_addr;
  logic [AREA_BITS-1:0] area;

  assign area = addr[ADDR_W-1 -: AREA_BITS];

  dram_area_map #(.N_SLOT(N_SLOT), .WAIT_W(WAIT_W)) u_map (
    .map_sel  (map_sel),
    .shift_bad(shift_sel[2]),
    .area     (area),
    .wait_cfg (wait_cfg),
    .dram_hit (dram_hit),
    .slot     (slot),
    .wait_n   (wait_n)
  );

  dram_addr_split #(.ADDR_W(ADDR_W), .MA_W(MA_W), .SHIFT_BASE(SHIFT_BASE), .N_SHIFT(4)) u_split (
    .addr     (addr),
    .shift_sel(shift_sel[1:0]),
    .row_key  (row_key),
    .row_addr (row_addr),
    .col_addr (col_addr)
  );

  dram_page_seq #(.ADDR_W(ADDR_W), .MA_W(MA_W), .N_SLOT(N_SLOT), .WAIT_W(WAIT_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .dram_hit(dram_hit),
    .slot    (slot),
    .row_key (row_key),
    .row_addr(row_addr),
    .col_addr(col_addr),
    .wait_n  (wait_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .ma      (dram_addr),
    .rdy     (rdy)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= shift_sel[2];
  end

  AST_CFG_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    shift_sel[2] |=> cfg_err); // R10

  AST_RESERVED_NO_RAS: assert property (@(posedge clk) disable iff (rst)
    (req && map_sel[2] && ras_n == '1) |=> (ras_n == '1)); // R1

  AST_CONT_SINGLE_RAS: assert property (@(posedge clk) disable iff (rst)
    (map_sel == MAP_CONT) |-> (ras_n[N_SLOT-1:1] == '1)); // R4

  AST_FOREIGN_AREA_IDLE: assert property (@(posedge clk) disable iff (rst)
    (req && (area < AREA_BITS'(FIRST_DRAM_AREA) || area >= AREA_BITS'(FIRST_DRAM_AREA + N_SLOT))
     && ras_n == '1) |=> (ras_n == '1)); // R12

endmodule

// File: tb/dram_mux_ctrl_tb.sv
module dram_mux_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [23:0] addr = '0;
  logic [2:0]  map_sel = '0;
  logic [2:0]  shift_sel = '0;
  logic [7:0]  wait_cfg = '0;
  logic [3:0]  ras_n;
  logic        cas_n;
  logic [11:0] dram_addr;
  logic        rdy;
  logic        cfg_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  bit          open_valid = 0;
  int          open_slot  = 0;
  logic [23:0] open_key   = '0;

  always #2 clk = ~clk;

  dram_mux_ctrl u_dut (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .map_sel(map_sel),
    .shift_sel(shift_sel), .wait_cfg(wait_cfg), .ras_n(ras_n), .cas_n(cas_n),
    .dram_addr(dram_addr), .rdy(rdy), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int f_slot(input logic [23:0] a);
    int ar = int'(a[23:21]);
    if (shift_sel[2]) return -1;
    case (map_sel)
      3'b001: return (ar == 2) ? 0 : -1;
      3'b010: return (ar == 2) ? 0 : (ar == 3) ? 1 : -1;
      3'b011: return (ar >= 2 && ar <= 5) ? 0 : -1;
      default: return -1;
    endcase
  endfunction

  function automatic int f_wait(input logic [23:0] a);
    int ar = int'(a[23:21]);
    if (map_sel == 3'b011) return int'(wait_cfg[1:0]);
    return int'(wait_cfg[(ar-2)*2 +: 2]);
  endfunction

  function automatic int f_shift();
    return 8 + int'(shift_sel[1:0]);
  endfunction

  function automatic logic [23:0] f_key(input logic [23:0] a);
    return a >> f_shift();
  endfunction

  function automatic logic [11:0] f_col(input logic [23:0] a);
    logic [23:0] m = (24'd1 << f_shift()) - 24'd1;
    return 12'(a & m);
  endfunction

  function automatic string f_map_req();
    case (map_sel)
      3'b001:  return "R2";
      3'b010:  return "R3";
      default: return "R4";
    endcase
  endfunction

  // Called at a negedge. Leaves the bench at the negedge of the rdy cycle.
  task automatic dram_access(input logic [23:0] a);
    int s = f_slot(a);
    bit hit = open_valid && (open_slot == s) && (open_key == f_key(a));
    bit miss_open = open_valid && !hit;
    int exp_pre = miss_open ? 4 : 1;
    int pre = 0;
    int ncas;
    bit saw_high = 0;
    logic [3:0]  last_ras = '1;
    logic [11:0] last_ma = '0;
    logic [3:0]  exp_ras = ~(4'b0001 << s);
    req = 1'b1;
    addr = a;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!cas_n) break;
      pre++;
      if (ras_n == 4'hf) saw_high = 1;
      last_ras = ras_n;
      last_ma = dram_addr;
    end
    if (hit) begin
      check(pre == 1, "R8 page-hit lead cycles", pre, 1);
      check(!saw_high, "R8 RAS held in page", saw_high, 0);
    end else begin
      check(pre == exp_pre, miss_open ? "R9 miss lead cycles" : "R5 lead cycles", pre, exp_pre);
      if (miss_open) check(saw_high, "R9 precharge seen", saw_high, 1);
      check(last_ras == exp_ras, f_map_req(), last_ras, exp_ras);
      check(last_ma == f_key(a)[11:0], "R5 row address", last_ma, f_key(a)[11:0]);
    end
    check(ras_n == exp_ras && dram_addr == f_col(a), "R6 column address/RAS",
          {ras_n, dram_addr}, {exp_ras, f_col(a)});
    ncas = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (cas_n) break;
      ncas++;
    end
    check(ncas == f_wait(a) + 1, (map_sel == 3'b011) ? "R4 area-2 wait count" : "R6 CAS width",
          ncas, f_wait(a) + 1);
    check(rdy && cas_n && ras_n == exp_ras, "R7 ready cycle", {rdy, cas_n, ras_n}, {2'b11, exp_ras});
    open_valid = 1;
    open_slot  = s;
    open_key   = f_key(a);
  endtask

  task automatic go_idle();
    req = 1'b0;
    @(negedge clk);
    check(!rdy, "R7 single pulse", rdy, 0);
    repeat (2) @(negedge clk);
    check(ras_n == 4'hf && cas_n, "R9 idle precharge", {ras_n, cas_n}, 5'h1f);
    open_valid = 0;
  endtask

  task automatic normal_access(input logic [23:0] a, input string rq);
    bit bad = 0;
    req = 1'b1;
    addr = a;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ras_n != 4'hf || rdy) bad = 1;
    end
    check(!bad, rq, bad, 0);
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic [2:0] sh, input logic [7:0] w);
    map_sel = m;
    shift_sel = sh;
    wait_cfg = w;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [23:0] rand_addr(input int ar);
    return {3'(ar), 21'($urandom)};
  endfunction

  function automatic logic [23:0] same_row(input logic [23:0] a);
    logic [23:0] m = (24'd1 << f_shift()) - 24'd1;
    return (a & ~m) | (24'($urandom) & m);
  endfunction

  task automatic access_any(input logic [23:0] a);
    if (f_slot(a) < 0) begin
      if (open_valid) go_idle();
      normal_access(a, (map_sel == 3'b000 || map_sel[2]) ? "R1 no DRAM" :
                       shift_sel[2] ? "R10 refused" : "R12 normal area");
    end else begin
      dram_access(a);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-requirements act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] a;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    check(ras_n == 4'hf && cas_n && !rdy && !cfg_err && dram_addr == 12'h0, "R11 reset state",
          {ras_n, cas_n, rdy, cfg_err, dram_addr}, {4'hf, 3'b100, 12'h0});
    rst = 1'b0;
    @(negedge clk);
    check(ras_n == 4'hf && cas_n && !rdy && !cfg_err, "R11 after reset",
          {ras_n, cas_n, rdy, cfg_err}, {4'hf, 3'b100});

    // R2: single area
    set_cfg(3'b001, 3'b000, 8'b11_10_01_10);
    dram_access(24'h45_6789);
    go_idle();
    normal_access(24'h65_0000, "R2 area3 normal");

    // R3: two areas, RAS change forces precharge (R9)
    set_cfg(3'b010, 3'b001, 8'b00_00_11_01);
    dram_access(24'h40_1234);
    dram_access(24'h60_1234);
    go_idle();
    normal_access(24'h80_0000, "R3 area4 normal");

    // R4: continuous, area-4 field differs from area-2 field
    set_cfg(3'b011, 3'b010, 8'b00_11_00_01);
    a = 24'h81_2345;
    dram_access(a);
    dram_access(same_row(a));
    dram_access(same_row(a));
    dram_access(24'hA1_2345);
    go_idle();

    // R1: reserved and all-normal codes
    set_cfg(3'b101, 3'b000, 8'h00);
    normal_access(24'h40_0000, "R1 reserved code");
    set_cfg(3'b000, 3'b000, 8'h00);
    normal_access(24'h40_0000, "R1 all normal");

    // R10: bad shift select
    set_cfg(3'b001, 3'b100, 8'h00);
    check(cfg_err, "R10 cfg_err flag", cfg_err, 1);
    normal_access(24'h40_0000, "R10 refused");
    set_cfg(3'b001, 3'b000, 8'h00);
    check(!cfg_err, "R10 cfg_err clears", cfg_err, 0);

    // R5: each shift amount, same address
    for (int sh = 0; sh < 4; sh++) begin
      set_cfg(3'b001, 3'(sh), 8'h01);
      dram_access(24'h5A_BCDE);
      go_idle();
    end

    // R12: foreign areas
    set_cfg(3'b011, 3'b000, 8'h00);
    normal_access(24'h00_1000, "R12 area0");
    normal_access(24'hE0_1000, "R12 area7");

    // random mix
    for (int r = 0; r < 40; r++) begin
      if (open_valid) go_idle();
      set_cfg(($urandom % 8 == 0) ? 3'b100 | 3'($urandom) : 3'($urandom % 4),
              3'($urandom % 4), 8'($urandom));
      a = rand_addr($urandom % 8);
      for (int k = 0; k < 6; k++) begin
        access_any(a);
        if ($urandom % 2 == 0) a = same_row(a);
        else a = rand_addr(2 + ($urandom % 4));
      end
    end
    if (open_valid) go_idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule